// File: doc/BRIEF.md
# Pi/4-Shift QPSK Symbol Encoder

This block turns a serial bit stream into a sequence of I/Q amplitude codes for a pi/4-shift QPSK modulator. Bits arrive on a single data pin, qualified by a one-cycle bit strobe on the system clock. Each pair of accepted bits forms a di-bit. The di-bit picks one of four phase increments, all odd multiples of 45 degrees. The increment is added to a phase index held modulo 8. Because the encoding is differential, the data is carried by the change of phase between symbols rather than by the absolute phase. Every symbol moves the carrier by at least 45 degrees.

For each symbol the block presents a signed 8-bit I code and a signed 8-bit Q code, ready for a pair of DACs, together with a one-cycle valid pulse. A test-mode pin replaces the serial data with a built-in pseudo-random sequence of period 511. The generator runs on the bit strobe, and its current bit is always driven on a monitor pin. Only the synchronous active-high reset initialises the generator, the phase and the bit pairing. A missing strobe leaves all of them untouched.

Top module: `pi4_qpsk_encoder`

## Requirements
- R1: While reset is high and in the first cycle after it, the outputs are I = +127, Q = 0 and sym_valid = 0. The phase index is 0 and the bit pairing is empty, so the first strobed bit after reset is the first bit of a pair.
- R2: Of each two strobed bits, the first is Xk and the second is Yk. sym_valid is high for exactly one cycle: the cycle after the clock edge that accepts the second bit. It is low at all other times.
- R3: The di-bit {Xk,Yk} moves the phase index (modulo 8, in 45-degree units) by +1 for 00, +3 for 01, -1 for 10 and -3 for 11.
- R4: Every symbol changes the (I,Q) pair, because no di-bit leaves the phase unchanged.
- R5: Phase index k produces I/Q = (127,0), (90,90), (0,127), (-90,90), (-127,0), (-90,-90), (0,-127), (90,-90) for k = 0 to 7, as two's-complement 8-bit codes.
- R6: I and Q hold their values in every cycle in which sym_valid is low.
- R7: While test_mode is high, the strobed bit is taken from the internal sequence and data_in has no effect on the symbols.
- R8: The internal sequence is a 9-bit LFSR with feedback x^9 + x^5 + 1. It is set to all ones by reset and advances once per strobe in either mode. pn_mon shows its top bit, which is the bit the next strobe consumes. The sequence repeats every 511 bits.
- R9: In cycles without a bit strobe, the sequence state, the phase and the half-assembled pair do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle strobe that accepts one serial bit |
| data_in | input | 1 | Serial data bit |
| test_mode | input | 1 | High selects the internal pseudo-random source |
| pn_mon | output | 1 | Current bit of the pseudo-random sequence |
| i_code | output | 8 | Signed in-phase amplitude code |
| q_code | output | 8 | Signed quadrature amplitude code |
| sym_valid | output | 1 | Pulses once per new symbol |

## Verification
Each of the four di-bits is first applied on its own from the reset phase, which separates the increment values and their signs. A long run of one di-bit walks the index all the way around the circle, exposing every lookup entry and the modulo-8 wrap. Random data with irregular gaps between strobes tests the pairing and the hold behaviour against an independent model. A reset in the middle of a pair shows that the pairing restarts. Test-mode runs drive toggling data_in while checking the symbols against the model, and record 1022 monitor bits to confirm that the sequence repeats after 511 bits. Strobe-free stretches with the mode pin moving show that the generator does not advance or reinitialise.

// File: rtl/qpsk_enc_pkg.sv
package qpsk_enc_pkg;

    localparam int PH_W    = 3;
    localparam int AMP_W   = 8;
    localparam int AMP_MAX = 127;
    localparam int AMP_DIA = 90;

    typedef logic [PH_W-1:0] phase_t;

    typedef struct packed {
        logic x;
        logic y;
    } dibit_t;

    typedef struct packed {
        logic signed [AMP_W-1:0] i;
        logic signed [AMP_W-1:0] q;
    } iq_t;

    // Differential step in 45-degree units, modulo 8
    function automatic phase_t phase_step(input dibit_t d);
        phase_t s;
        case ({d.x, d.y})
            2'b00:   s = phase_t'(1);
            2'b01:   s = phase_t'(3);
            2'b10:   s = phase_t'(7);
            default: s = phase_t'(5);
        endcase
        return s;
    endfunction

    // Constellation point for a phase index
    function automatic iq_t iq_point(input phase_t p);
        iq_t r;
        case (p)
            3'd0:    begin r.i = AMP_W'(AMP_MAX);  r.q = AMP_W'(0);        end
            3'd1:    begin r.i = AMP_W'(AMP_DIA);  r.q = AMP_W'(AMP_DIA);  end
            3'd2:    begin r.i = AMP_W'(0);        r.q = AMP_W'(AMP_MAX);  end
            3'd3:    begin r.i = AMP_W'(-AMP_DIA); r.q = AMP_W'(AMP_DIA);  end
            3'd4:    begin r.i = AMP_W'(-AMP_MAX); r.q = AMP_W'(0);        end
            3'd5:    begin r.i = AMP_W'(-AMP_DIA); r.q = AMP_W'(-AMP_DIA); end
            3'd6:    begin r.i = AMP_W'(0);        r.q = AMP_W'(-AMP_MAX); end
            default: begin r.i = AMP_W'(AMP_DIA);  r.q = AMP_W'(-AMP_DIA); end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pn_source.sv
module pn_source #(
    parameter int LEN = 9,
    parameter int TAP = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic bit_o
);
    logic [LEN-1:0] state;
    logic           fb;

    assign fb    = state[LEN-1] ^ state[TAP-1];
    assign bit_o = state[LEN-1];

    always_ff @(posedge clk) begin
        if (rst)      state <= '1;
        else if (adv) state <= {state[LEN-2:0], fb};
    end

    // R8: a maximal-length register never reaches the all-zero lock-up state
    assert_lfsr_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
        state != '0);

    // R9: no strobe, no advance
    assert_lfsr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state));
endmodule

// File: rtl/dibit_pack.sv
module dibit_pack
    import qpsk_enc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bit_en,
    input  logic   bit_i,
    output logic   pair_vld,
    output dibit_t pair
);
    logic half;
    logic x_hold;

    assign pair_vld = bit_en & half;
    assign pair.x   = x_hold;
    assign pair.y   = bit_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            half   <= 1'b0;
            x_hold <= 1'b0;
        end else if (bit_en) begin
            half <= ~half;
            if (!half) x_hold <= bit_i;
        end
    end

    // R9: pairing state only moves with a strobe
    assert_pair_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(half) && $stable(x_hold));

    // R2: a completed pair always empties the assembly
    assert_pair_clear_R2: assert property (@(posedge clk) disable iff (rst)
        pair_vld |=> !half);
endmodule

// File: rtl/phase_mapper.sv
module phase_mapper
    import qpsk_enc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   step_en,
    input  dibit_t step_bits,
    output iq_t    iq,
    output logic   sym_valid
);
    phase_t phase;
    phase_t phase_nx;

    assign phase_nx = phase + phase_step(step_bits);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= '0;
            iq        <= iq_point('0);
            sym_valid <= 1'b0;
        end else begin
            sym_valid <= step_en;
            if (step_en) begin
                phase <= phase_nx;
                iq    <= iq_point(phase_nx);
            end
        end
    end

    // R4: the phase index moves on every symbol
    assert_phase_moves_R4: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> phase != $past(phase));

    // R9: phase held between symbols
    assert_phase_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(phase));
endmodule

// File: rtl/pi4_qpsk_encoder.sv
module pi4_qpsk_encoder
    import qpsk_enc_pkg::*;
#(
    parameter int PN_LEN = 9,
    parameter int PN_TAP = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             data_in,
    input  logic             test_mode,
    output logic             pn_mon,
    output logic [AMP_W-1:0] i_code,
    output logic [AMP_W-1:0] q_code,
    output logic             sym_valid
);
    logic   pn_bit;
    logic   src_bit;
    logic   pair_vld;
    dibit_t pair;
    iq_t    iq;

    pn_source #(.LEN(PN_LEN), .TAP(PN_TAP)) u_pn (
        .clk   (clk),
        .rst   (rst),
        .adv   (bit_en),
        .bit_o (pn_bit)
    );

    assign src_bit = test_mode ? pn_bit : data_in;
    assign pn_mon  = pn_bit;

    dibit_pack u_pack (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .bit_i    (src_bit),
        .pair_vld (pair_vld),
        .pair     (pair)
    );

    phase_mapper u_map (
        .clk       (clk),
        .rst       (rst),
        .step_en   (pair_vld),
        .step_bits (pair),
        .iq        (iq),
        .sym_valid (sym_valid)
    );

    assign i_code = iq.i;
    assign q_code = iq.q;

    // R2: a symbol pulse only follows an accepted bit
    assert_valid_after_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> $past(bit_en));

    // R2: pulses are one cycle long
    assert_valid_single_R2: assert property (@(posedge clk) disable iff (rst)
        sym_valid |=> !sym_valid);

    // R4: each new symbol lands on a different constellation point
    assert_point_changes_R4: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> {i_code, q_code} != $past({i_code, q_code}));

    // R6: outputs hold between symbols
    assert_iq_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |-> $stable(i_code) && $stable(q_code));
endmodule

// File: tb/test_pi4_qpsk_encoder.sv
module test_pi4_qpsk_encoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       data_in = 1'b0;
    logic       test_mode = 1'b0;
    logic       pn_mon;
    logic [7:0] i_code;
    logic [7:0] q_code;
    logic       sym_valid;

    int n_chk = 0;
    int n_err = 0;

    // reference model state
    int m_lfsr;
    int m_phase;
    int m_half;
    int m_x;
    int e_i, e_q, e_sv;
    int cos_t [8] = '{127, 90, 0, -90, -127, -90, 0, 90};
    int sin_t [8] = '{0, 90, 127, 90, 0, -90, -127, -90};
    bit pn_rec [1022];

    always #5 clk = ~clk;

    pi4_qpsk_encoder i_pi4_qpsk_encoder (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .data_in   (data_in),
        .test_mode (test_mode),
        .pn_mon    (pn_mon),
        .i_code    (i_code),
        .q_code    (q_code),
        .sym_valid (sym_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_lfsr = 511; m_phase = 0; m_half = 0; m_x = 0;
        e_i = 127; e_q = 0; e_sv = 0;
    endtask

    function automatic int step_of(input int x, input int y);
        if (x == 0 && y == 0) return 1;
        if (x == 0 && y == 1) return 3;
        if (x == 1 && y == 0) return -1;
        return -3;
    endfunction

    task automatic check_out(input string tag);
        chk(int'(sym_valid) == e_sv, "R2 sym_valid", int'(sym_valid), e_sv);
        chk($signed(i_code) == e_i, {tag, " I"}, $signed(i_code), e_i);
        chk($signed(q_code) == e_q, {tag, " Q"}, $signed(q_code), e_q);
    endtask

    // one clock: drive at the falling edge, check after the next rising edge
    task automatic step(input bit en, input bit d, input bit m, input string tag);
        int b;
        int top;
        bit_en = en; data_in = d; test_mode = m;
        #1;
        top = (m_lfsr >> 8) & 1;
        chk(int'(pn_mon) == top, "R8 pn_mon", int'(pn_mon), top);
        e_sv = 0;
        if (en) begin
            b = m ? top : int'(d);
            m_lfsr = ((m_lfsr << 1) | (top ^ ((m_lfsr >> 4) & 1))) & 511;
            if (m_half == 1) begin
                m_phase = (m_phase + step_of(m_x, b) + 8) % 8;
                e_i = cos_t[m_phase]; e_q = sin_t[m_phase]; e_sv = 1;
                m_half = 0;
            end else begin
                m_x = b; m_half = 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; bit_en = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        check_out("R1 in reset");
        chk(int'(pn_mon) == 1, "R1 pn seed", int'(pn_mon), 1);
        rst = 1'b0;
        @(negedge clk);
        check_out("R1 after reset");
    endtask

    task automatic send_dibit(input bit x, input bit y, input string tag);
        step(1'b1, x, 1'b0, tag);
        step(1'b1, y, 1'b0, tag);
    endtask

    initial begin
        #1500000;
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int pi, pq;
        @(negedge clk);
        do_reset();

        // R3: each di-bit from phase 0
        send_dibit(1'b0, 1'b0, "R3 00");
        do_reset(); send_dibit(1'b0, 1'b1, "R3 01");
        do_reset(); send_dibit(1'b1, 1'b0, "R3 10");
        do_reset(); send_dibit(1'b1, 1'b1, "R3 11");

        // R5/R4: walk the circle with 00, then backwards with 10
        do_reset();
        for (int k = 0; k < 10; k++) begin
            pi = e_i; pq = e_q;
            send_dibit(1'b0, 1'b0, "R5 walk");
            chk((e_i != pi) || (e_q != pq), "R4 moved", e_i, pi);
        end
        for (int k = 0; k < 10; k++) send_dibit(1'b1, 1'b0, "R5 back");

        // R6/R9: idle stretch with mode pin toggling
        for (int k = 0; k < 6; k++) step(1'b0, k[0], k[1], "R6 idle");
        step(1'b1, 1'b1, 1'b0, "R9 half");
        for (int k = 0; k < 5; k++) step(1'b0, 1'b0, k[0], "R9 gap");
        step(1'b1, 1'b0, 1'b0, "R9 complete");

        // R2: random data with irregular gaps
        for (int k = 0; k < 400; k++) begin
            step(($urandom % 3) != 0, $urandom % 2, 1'b0, "R2 random");
        end

        // R1: reset in the middle of a pair restarts pairing
        step(1'b1, 1'b1, 1'b0, "R1 pre");
        do_reset();
        send_dibit(1'b0, 1'b1, "R1 fresh pair");

        // R7/R8: test mode with toggling data_in
        do_reset();
        for (int k = 0; k < 1022; k++) begin
            pn_rec[k] = pn_mon;
            step(1'b1, k[0], 1'b1, "R7 test mode");
        end
        for (int k = 0; k < 511; k++) begin
            chk(pn_rec[k] == pn_rec[k + 511], "R8 period", int'(pn_rec[k + 511]), int'(pn_rec[k]));
        end
        for (int k = 0; k < 200; k++) begin
            step(($urandom % 2) != 0, $urandom % 2, ($urandom % 4) != 0, "R7 mixed");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule